// File: doc/BRIEF.md
# Triggered Exposure Line Sequencer

This block runs externally triggered exposures for a progressive-scan image sensor. All of its timing is counted in lines. A one-cycle line-sync strobe marks the start of each line. A short, fixed number of clock cycles after each strobe, the block samples three active-low control inputs: the trigger, the early-end request and the drain request. A falling level between two consecutive samples counts as an edge.

A sampled trigger edge arms the sequencer, and exposure starts at the following line sync. The busy flag stays high from that sync until the readout line has finished. Exposure ends in one of three ways: when a programmed number of lines has elapsed, when a fixed 315-line period (one fiftieth of a second at 525 lines per thirtieth) has elapsed, or at the sync after an accepted early-end edge. The readout request is then high for exactly one line. Busy falls together with the readout request, and the sequencer returns to idle.

When the clear option is selected and the first mode bit is low, a charge-clear enable is raised for a fixed number of lines at the start of exposure. The shutter mode, the line count and the clear option are captured at the moment the trigger arms the sequencer.

Top module: `xtrig_seq`

## Requirements
- R1: A trigger edge sampled while idle arms the sequencer. `busy` rises at the next line sync, not at the sync whose sample window held the edge.
- R2: After reset, `busy`, `readout_req` and `clear_en` are low. `readout_req` stays high for exactly one line, from one line sync to the next. `busy` falls at the same sync as `readout_req`, and the sequencer is then idle.
- R3: With `shut_mode` = 2'b01, or with 2'b00 and `par_sel` low, `readout_req` rises N line syncs after `busy` rises, where N is `line_count`. A count of 0 is taken as 1.
- R4: With `shut_mode` = 2'b11, `readout_req` rises 315 line syncs after `busy` rises, whatever `line_count` holds.
- R5: A trigger edge is ignored when `shut_mode` = 2'b10, or when `shut_mode` = 2'b00 with `par_sel` high.
- R6: An early-end edge sampled during exposure, with `early_bypass` low, moves the readout to the next line sync. Early-end edges are ignored while `early_bypass` is high or the sequencer is not exposing, and only one is honoured per trigger.
- R7: When `clear_req` is high and `shut_mode[1]` is low at arming, `clear_en` is high from the sync that starts exposure for 3 lines (parameter `CLEAR_LINES`). It is cut short when `busy` falls and is never raised while `shut_mode[1]` is high.
- R8: The inputs are sampled only `SAMPLE_DLY`+1 clock cycles after each line sync. A trigger pulse that begins after that sample and ends before the next sync has no effect.
- R9: If two or more of `trig_n`, `early_n` and `drain_n` fall within the same sample, that sample produces no action.
- R10: Trigger edges sampled while the sequencer is armed or busy are ignored and do not change when the episode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_stb | input | 1 | One-cycle line-sync strobe |
| trig_n | input | 1 | Trigger, active low |
| early_n | input | 1 | Early-end request, active low |
| drain_n | input | 1 | Drain request, active low (used in collision rule) |
| par_sel | input | 1 | Mode bits come from pins (1) or a serial register (0) |
| shut_mode | input | 2 | Shutter mode select |
| early_bypass | input | 1 | High: early-end requests ignored |
| clear_req | input | 1 | Request charge clear after trigger |
| line_count | input | LINE_W | Programmed exposure length in lines |
| busy | output | 1 | High through the trigger episode |
| clear_en | output | 1 | Charge-clear enable |
| readout_req | output | 1 | One-line readout request |

## Verification
The overlap that matters is an early-end edge arriving in the same line in which the programmed count expires. Both causes then want the readout at the same sync. The bench sweeps the early-end line across every exposure line of a 6-line episode, including the last one, and predicts the readout line as the smaller of the two end points. A second overlap is a trigger edge and an early-end or drain edge in one sample. The bench drives these together and expects no episode at all.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_EXPOSE  = 2'd2,
    ST_READOUT = 2'd3
  } seq_state_t;

  // Mode acceptance: 2'b10 never, 2'b00 only from the serial register.
  function automatic logic trig_accepted(input logic par, input logic [1:0] sm);
    return !(sm == 2'b10) && !(par && (sm == 2'b00));
  endfunction

  // Exposure length in lines for a given mode.
  function automatic int unsigned expo_lines(input logic [1:0] sm,
                                             input int unsigned cnt,
                                             input int unsigned fixed_len);
    if (sm == 2'b11) return fixed_len;
    if (cnt == 0)    return 1;
    return cnt;
  endfunction

  // Charge clear only permitted when the first mode bit is low.
  function automatic logic clear_allowed(input logic fse, input logic [1:0] sm);
    return fse && !sm[1];
  endfunction

endpackage

// File: rtl/xtrig_sampler.sv
module xtrig_sampler #(
  parameter int SAMPLE_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hd_stb,
  input  logic trig_n,
  input  logic early_n,
  input  logic drain_n,
  output logic ev_trig,
  output logic ev_early
);
  localparam int WIN_W = (SAMPLE_DLY < 1) ? 1 : $clog2(SAMPLE_DLY + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_live;
  logic             sample_now;
  logic [2:0]       prev_lvl;
  logic [2:0]       cur_lvl;
  logic [2:0]       falls;
  logic             collide;

  assign sample_now = win_live && (win_cnt == WIN_W'(SAMPLE_DLY));
  assign cur_lvl    = {drain_n, early_n, trig_n};
  assign falls      = prev_lvl & ~cur_lvl;
  assign collide    = (falls[0] & falls[1]) | (falls[0] & falls[2]) | (falls[1] & falls[2]);

  // Detection window counter restarted by each line sync.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      win_live <= 1'b0;
    end else if (hd_stb) begin
      win_cnt  <= '0;
      win_live <= 1'b1;
    end else if (win_live) begin
      if (sample_now) win_live <= 1'b0;
      else            win_cnt  <= win_cnt + 1'b1;
    end
  end

  // Level history and edge events, emitted one cycle after the sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl <= 3'b111;
      ev_trig  <= 1'b0;
      ev_early <= 1'b0;
    end else if (sample_now) begin
      prev_lvl <= cur_lvl;
      ev_trig  <= falls[0] & !collide;
      ev_early <= falls[1] & !collide;
    end else begin
      ev_trig  <= 1'b0;
      ev_early <= 1'b0;
    end
  end

  a_r9_collision_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_now && collide) |=> (!ev_trig && !ev_early));

  a_r8_events_from_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trig || ev_early) |-> $past(sample_now));

endmodule

// File: rtl/xtrig_line_timer.sv
module xtrig_line_timer #(
  parameter int CNT_W       = 11,
  parameter int CLEAR_LINES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_stb,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] tgt,
  input  logic             clr_arm,
  output logic             last_line,
  output logic             clr_active
);
  localparam int CLR_W = (CLEAR_LINES < 1) ? 1 : $clog2(CLEAR_LINES + 1);

  logic [CNT_W-1:0] line_cnt;
  logic [CLR_W-1:0] clr_cnt;

  // Lines elapsed since exposure start; last when the next sync completes tgt.
  assign last_line  = ({1'b0, line_cnt} + (CNT_W+1)'(1)) >= {1'b0, tgt};
  assign clr_active = (clr_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (start) begin
      line_cnt <= '0;
    end else if (run && hd_stb) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_cnt <= '0;
    end else if (start) begin
      clr_cnt <= clr_arm ? CLR_W'(CLEAR_LINES) : '0;
    end else if (!run) begin
      clr_cnt <= '0;
    end else if (hd_stb && clr_active) begin
      clr_cnt <= clr_cnt - 1'b1;
    end
  end

  a_r7_clear_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_active) |-> $past(start) && $past(clr_arm));

endmodule

// File: rtl/xtrig_fsm.sv
module xtrig_fsm
  import xtrig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hd_stb,
  input  logic ev_trig,
  input  logic ev_early,
  input  logic accept,
  input  logic early_bypass,
  input  logic last_line,
  output logic arm,
  output logic start,
  output logic busy,
  output logic readout_req
);
  seq_state_t state;
  logic       early_seen;

  assign arm         = (state == ST_IDLE) && ev_trig && accept;
  assign start       = (state == ST_ARMED) && hd_stb;
  assign busy        = (state == ST_EXPOSE) || (state == ST_READOUT);
  assign readout_req = (state == ST_READOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (arm)    state <= ST_ARMED;
        ST_ARMED:   if (hd_stb) state <= ST_EXPOSE;
        ST_EXPOSE:  if (hd_stb && (early_seen || last_line)) state <= ST_READOUT;
        ST_READOUT: if (hd_stb) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // One early-end per trigger, only while exposing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early_seen <= 1'b0;
    end else if (start) begin
      early_seen <= 1'b0;
    end else if ((state == ST_EXPOSE) && ev_early && !early_bypass) begin
      early_seen <= 1'b1;
    end
  end

  a_r1_busy_rises_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hd_stb));

  a_r2_busy_falls_with_readout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readout_req) |-> $fell(busy));

  a_r2_readout_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_req && !hd_stb) |=> readout_req);

  a_r10_arm_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) && !$past(state == ST_ARMED) |-> $past(state == ST_IDLE));

endmodule

// File: rtl/xtrig_seq.sv
module xtrig_seq
  import xtrig_pkg::*;
#(
  parameter int LINE_W         = 10,
  parameter int SAMPLE_DLY     = 4,
  parameter int CLEAR_LINES    = 3,
  parameter int FIFTIETH_LINES = 315
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_stb,
  input  logic              trig_n,
  input  logic              early_n,
  input  logic              drain_n,
  input  logic              par_sel,
  input  logic [1:0]        shut_mode,
  input  logic              early_bypass,
  input  logic              clear_req,
  input  logic [LINE_W-1:0] line_count,
  output logic              busy,
  output logic              clear_en,
  output logic              readout_req
);
  localparam int CNT_W = LINE_W + 1;

  logic             ev_trig;
  logic             ev_early;
  logic             arm;
  logic             start;
  logic             last_line;
  logic             clr_active;
  logic             accept_now;
  logic [CNT_W-1:0] tgt_now;
  logic [CNT_W-1:0] tgt_q;
  logic             clr_q;

  assign accept_now = trig_accepted(par_sel, shut_mode);
  assign tgt_now    = CNT_W'(expo_lines(shut_mode, int'(line_count), FIFTIETH_LINES));

  // Mode captured when the trigger arms.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= CNT_W'(1);
      clr_q <= 1'b0;
    end else if (arm) begin
      tgt_q <= tgt_now;
      clr_q <= clear_allowed(clear_req, shut_mode);
    end
  end

  xtrig_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_stb   (hd_stb),
    .trig_n   (trig_n),
    .early_n  (early_n),
    .drain_n  (drain_n),
    .ev_trig  (ev_trig),
    .ev_early (ev_early)
  );

  xtrig_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hd_stb       (hd_stb),
    .ev_trig      (ev_trig),
    .ev_early     (ev_early),
    .accept       (accept_now),
    .early_bypass (early_bypass),
    .last_line    (last_line),
    .arm          (arm),
    .start        (start),
    .busy         (busy),
    .readout_req  (readout_req)
  );

  xtrig_line_timer #(.CNT_W(CNT_W), .CLEAR_LINES(CLEAR_LINES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .hd_stb     (hd_stb),
    .start      (start),
    .run        (busy),
    .tgt        (tgt_q),
    .clr_arm    (clr_q),
    .last_line  (last_line),
    .clr_active (clr_active)
  );

  assign clear_en = clr_active && busy;

  a_r7_clear_starts_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_en) |-> $past(hd_stb) && $rose(busy));

  a_r5_rejected_mode_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trig && !accept_now) |=> !$rose(busy));

endmodule

// File: tb/tb_xtrig_seq.sv
module tb_xtrig_seq;
  localparam int LINE_W     = 10;
  localparam int LINE_CYC   = 40;
  localparam int CLR        = 3;
  localparam int FIXED_LEN  = 315;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_stb = 1'b0;
  logic trig_n = 1'b1, early_n = 1'b1, drain_n = 1'b1;
  logic par_sel = 1'b0;
  logic [1:0] shut_mode = 2'b01;
  logic early_bypass = 1'b0;
  logic clear_req = 1'b0;
  logic [LINE_W-1:0] line_count = '0;
  logic busy, clear_en, readout_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic s_busy, s_clr, s_rd;

  always #5 clk = ~clk;

  xtrig_seq #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .hd_stb(hd_stb), .trig_n(trig_n),
    .early_n(early_n), .drain_n(drain_n), .par_sel(par_sel),
    .shut_mode(shut_mode), .early_bypass(early_bypass), .clear_req(clear_req),
    .line_count(line_count), .busy(busy), .clear_en(clear_en),
    .readout_req(readout_req)
  );

  task automatic chk(input string tag, input string what, input int k,
                     input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s line %0d %s got %b exp %b", tag, k, what, got, exp);
    end
  endtask

  // One line: set levels, pulse the sync, sample outputs mid-line.
  task automatic run_line(input logic t, input logic e, input logic d, input bit late);
    @(negedge clk);
    trig_n = t; early_n = e; drain_n = d; hd_stb = 1'b1;
    @(negedge clk);
    hd_stb = 1'b0;
    for (int c = 1; c < LINE_CYC; c++) begin
      @(negedge clk);
      if (late && c == 12) trig_n = 1'b0;
      if (late && c == 16) trig_n = 1'b1;
      if (c == 20) begin s_busy = busy; s_clr = clear_en; s_rd = readout_req; end
    end
  endtask

  // collide: 0 none, 1 with early-end, 2 with drain
  task automatic episode(input string tag, input logic [1:0] sm, input bit par,
                         input bit fse, input bit byp, input int n,
                         input int esg_line, input int retrig_line,
                         input int collide, input bit late);
    bit acc;
    int tgt, rl, total, clr_end;
    shut_mode = sm; par_sel = par; clear_req = fse; early_bypass = byp;
    line_count = LINE_W'(n);
    acc = !(sm == 2'b10) && !(par && sm == 2'b00) && (collide == 0) && !late;
    tgt = (sm == 2'b11) ? FIXED_LEN : ((n == 0) ? 1 : n);
    rl  = 2 + tgt;
    if (!byp && esg_line >= 2 && esg_line <= 1 + tgt) rl = esg_line + 1;
    total = acc ? rl + 2 : 5;
    if (esg_line + 2 > total) total = esg_line + 2;
    if (retrig_line + 2 > total) total = retrig_line + 2;
    clr_end = (1 + CLR < rl) ? 1 + CLR : rl;
    for (int k = 0; k < total; k++) begin
      logic t, e, d;
      t = !(((k == 1) && !late) || (k == retrig_line));
      e = !((k == esg_line) || (k == 1 && collide == 1));
      d = !(k == 1 && collide == 2);
      run_line(t, e, d, late && k == 1);
      chk(tag, "busy", k, s_busy, acc && k >= 2 && k <= rl);
      chk(tag, "readout_req", k, s_rd, acc && k == rl);
      chk(tag, "clear_en", k, s_clr, acc && fse && !sm[1] && k >= 2 && k <= clr_end);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset busy", 0, busy, 1'b0);
    chk("R2", "reset readout_req", 0, readout_req, 1'b0);
    chk("R2", "reset clear_en", 0, clear_en, 1'b0);

    // R1, R2, R3: counted exposure, pin and register mode bits
    for (int n = 0; n <= 5; n++) begin
      episode("R3", 2'b01, 1'b1, 1'b0, 1'b0, n, -1, -1, 0, 1'b0);
      episode("R1", 2'b01, 1'b0, 1'b0, 1'b0, n, -1, -1, 0, 1'b0);
    end
    for (int n = 1; n <= 3; n++)
      episode("R3", 2'b00, 1'b0, 1'b0, 1'b0, n, -1, -1, 0, 1'b0);
    // R4: fixed length, clear requested but suppressed (R7)
    episode("R4", 2'b11, 1'b1, 1'b1, 1'b0, 7, -1, -1, 0, 1'b0);
    // R5: rejected modes
    episode("R5", 2'b00, 1'b1, 1'b0, 1'b0, 2, -1, -1, 0, 1'b0);
    episode("R5", 2'b10, 1'b1, 1'b0, 1'b0, 2, -1, -1, 0, 1'b0);
    episode("R5", 2'b10, 1'b0, 1'b0, 1'b0, 2, -1, -1, 0, 1'b0);
    // R6: early end across every exposure line, bypass, outside exposure
    for (int e = 2; e <= 7; e++)
      episode("R6", 2'b01, 1'b1, 1'b0, 1'b0, 6, e, -1, 0, 1'b0);
    episode("R6", 2'b01, 1'b1, 1'b0, 1'b1, 6, 4, -1, 0, 1'b0);
    episode("R6", 2'b01, 1'b1, 1'b0, 1'b0, 3, 9, -1, 0, 1'b0);
    episode("R6", 2'b11, 1'b1, 1'b0, 1'b0, 0, 5, -1, 0, 1'b0);
    // R7: clear with counted exposure, short and long
    for (int n = 1; n <= 5; n++)
      episode("R7", 2'b01, 1'b1, 1'b1, 1'b0, n, -1, -1, 0, 1'b0);
    episode("R7", 2'b01, 1'b1, 1'b1, 1'b0, 6, 3, -1, 0, 1'b0);
    // R8: pulse between windows
    episode("R8", 2'b01, 1'b1, 1'b0, 1'b0, 2, -1, -1, 0, 1'b1);
    // R9: simultaneous falls
    episode("R9", 2'b01, 1'b1, 1'b0, 1'b0, 2, -1, -1, 1, 1'b0);
    episode("R9", 2'b01, 1'b1, 1'b0, 1'b0, 2, -1, -1, 2, 1'b0);
    // R10: trigger again while busy
    episode("R10", 2'b01, 1'b1, 1'b0, 1'b0, 5, -1, 3, 0, 1'b0);
    episode("R10", 2'b01, 1'b1, 1'b0, 1'b0, 3, -1, 2, 0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule